// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where the instruction stream of a 32-bit, byte-addressed RISC core goes next. Every instruction is one aligned 32-bit word. The block holds the program counter and reads the fetched instruction word. It also takes the two register operands that the core has already read for that instruction. From these it computes the following fetch address. It covers straight-line flow, the two equality-tested conditional branches, the region-limited absolute jump, the jump through a register, and the jump that also saves a return address.

The block only decodes the opcode and function fields it needs to choose the next address. The register file, the ALU, the memories and the fetch path all sit outside it. When a call instruction is seen, the block raises a write strobe and presents the return address and the destination register index. The core's register file then does the actual write. The program counter advances to the computed address on each clock where the step input is high.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the program counter with 0, and the counter stays 0 while reset is held.
- R2: On a clock edge with `step_en` high, the counter takes the value of `next_pc`; with `step_en` low it keeps its value.
- R3: Any instruction other than the five control transfers gives `next_pc` = pc + 4 with `link_we` low. The opcode is bits 31..26, and the function field is bits 5..0.
- R4: The branch-if-equal instruction has opcode 4. When `rs_value` equals `rt_value`, `next_pc` = pc + 4 + (the signed 16-bit field in bits 15..0, times 4). Otherwise `next_pc` = pc + 4.
- R5: The branch-if-not-equal instruction has opcode 5. It uses the same target as R4, but it is taken only when the two operands differ.
- R6: The absolute jump has opcode 2. `next_pc` = {pc[31:28], bits 25..0 of the instruction, 2'b00}, so the top four bits of the counter are kept.
- R7: The jump-and-link instruction has opcode 3. It jumps to the R6 target and raises `link_we`, with `link_val` = pc + 4 and `link_dst` = 31.
- R8: The jump-to-register instruction has opcode 0 with function 8. It gives `next_pc` = `rs_value` with `link_we` low. Opcode 0 with any other function value is sequential.
- R9: `link_we` is high only for the jump-and-link instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the program counter on this edge |
| instr_word | input | 32 | Instruction fetched at the current counter value |
| rs_value | input | 32 | Value of the register named in bits 25..21 |
| rt_value | input | 32 | Value of the register named in bits 20..16 |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the following instruction |
| link_we | output | 1 | Return-address write strobe |
| link_dst | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address to be written |

## Verification
Several corner cases are targeted directly:
- Branch offsets that are negative, including the most negative one. A unit that zero-extends the offset would jump forward instead of back.
- A branch at byte 80012 with offset 2, which must land on 80024. A unit that adds the offset to pc instead of pc + 4, or forgets the times-four scaling, lands elsewhere.
- Jumps issued with nonzero upper counter bits. These catch a target that drops the region bits.
- Jump-and-link, checked for the link strobe, the link value and the link index.
- The jump-to-register case, probed next to a neighbouring function code. This catches a decoder that ignores the function field.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int OPC_W     = 6;
    localparam int FN_W      = 6;
    localparam int OFS_W     = 16;
    localparam int JFLD_W    = 26;
    localparam int REGIDX_W  = 5;
    localparam int REGION_W  = XLEN - JFLD_W - 2;
    localparam int OFS_EXT_W = XLEN - OFS_W - 2;
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JABS    = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JCALL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        XF_SEQ,
        XF_BR_EQ,
        XF_BR_NE,
        XF_JABS,
        XF_JCALL,
        XF_JREG
    } xfer_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [FN_W-1:0]   funct;
        logic [OFS_W-1:0]  offset;
        logic [JFLD_W-1:0] jfield;
    } insn_fields_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } targets_t;

    function automatic insn_fields_t split_word(input logic [XLEN-1:0] w);
        insn_fields_t f;
        f.opcode = w[XLEN-1 -: OPC_W];
        f.funct  = w[FN_W-1:0];
        f.offset = w[OFS_W-1:0];
        f.jfield = w[JFLD_W-1:0];
        return f;
    endfunction

    function automatic xfer_e classify(input logic [OPC_W-1:0] op,
                                       input logic [FN_W-1:0]  fn);
        xfer_e k;
        unique case (op)
            OPC_BR_EQ:   k = XF_BR_EQ;
            OPC_BR_NE:   k = XF_BR_NE;
            OPC_JABS:    k = XF_JABS;
            OPC_JCALL:   k = XF_JCALL;
            OPC_SPECIAL: k = (fn == FN_JREG) ? XF_JREG : XF_SEQ;
            default:     k = XF_SEQ;
        endcase
        return k;
    endfunction

    function automatic logic [XLEN-1:0] scale_offset(input logic [OFS_W-1:0] o);
        return {{OFS_EXT_W{o[OFS_W-1]}}, o, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]   instr_word,
    output logic [OFS_W-1:0]  offset,
    output logic [JFLD_W-1:0] jfield,
    output xfer_e             kind
);
    insn_fields_t f;

    always_comb begin
        f      = split_word(instr_word);
        kind   = classify(f.opcode, f.funct);
        offset = f.offset;
        jfield = f.jfield;
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]   pc,
    input  logic [OFS_W-1:0]  offset,
    input  logic [JFLD_W-1:0] jfield,
    output targets_t          tgt
);
    always_comb begin
        tgt.seq    = pc + INSN_BYTES;
        tgt.branch = tgt.seq + scale_offset(offset);
        tgt.jump   = {pc[XLEN-1 -: REGION_W], jfield, 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  xfer_e           kind,
    input  targets_t        tgt,
    input  logic [XLEN-1:0] rs_value,
    input  logic [XLEN-1:0] rt_value,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we
);
    logic same;

    always_comb begin
        same    = (rs_value == rt_value);
        next_pc = tgt.seq;
        link_we = 1'b0;
        unique case (kind)
            XF_BR_EQ: if (same)  next_pc = tgt.branch;
            XF_BR_NE: if (!same) next_pc = tgt.branch;
            XF_JABS:  next_pc = tgt.jump;
            XF_JCALL: begin
                next_pc = tgt.jump;
                link_we = 1'b1;
            end
            XF_JREG:  next_pc = rs_value;
            default:  next_pc = tgt.seq;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0]     RESET_VEC = '0,
    parameter logic [REGIDX_W-1:0] LINK_IDX  = 5'd31
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic [XLEN-1:0]     instr_word,
    input  logic [XLEN-1:0]     rs_value,
    input  logic [XLEN-1:0]     rt_value,
    output logic [XLEN-1:0]     pc,
    output logic [XLEN-1:0]     next_pc,
    output logic                link_we,
    output logic [REGIDX_W-1:0] link_dst,
    output logic [XLEN-1:0]     link_val
);
    logic [OFS_W-1:0]  offset;
    logic [JFLD_W-1:0] jfield;
    xfer_e             kind;
    targets_t          tgt;

    npc_decode u_dec (
        .instr_word (instr_word),
        .offset     (offset),
        .jfield     (jfield),
        .kind       (kind)
    );

    npc_targets u_tgt (
        .pc     (pc),
        .offset (offset),
        .jfield (jfield),
        .tgt    (tgt)
    );

    npc_select u_sel (
        .kind     (kind),
        .tgt      (tgt),
        .rs_value (rs_value),
        .rt_value (rt_value),
        .next_pc  (next_pc),
        .link_we  (link_we)
    );

    assign link_dst = LINK_IDX;
    assign link_val = tgt.seq;

    always_ff @(posedge clk) begin
        if (rst)          pc <= RESET_VEC;
        else if (step_en) pc <= next_pc;
    end
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker
    import npc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                step_en,
    input logic [XLEN-1:0]     instr_word,
    input logic [XLEN-1:0]     rs_value,
    input logic [XLEN-1:0]     rt_value,
    input logic [XLEN-1:0]     pc,
    input logic [XLEN-1:0]     next_pc,
    input logic                link_we,
    input logic [REGIDX_W-1:0] link_dst,
    input logic [XLEN-1:0]     link_val
);
    logic [OPC_W-1:0] op;
    logic             is_ctl;
    assign op     = instr_word[XLEN-1 -: OPC_W];
    assign is_ctl = (op == OPC_BR_EQ) || (op == OPC_BR_NE) || (op == OPC_JABS) ||
                    (op == OPC_JCALL) ||
                    (op == OPC_SPECIAL && instr_word[FN_W-1:0] == FN_JREG);

    a_r1_reset_vector: assert property (@(posedge clk)
        rst |=> pc == '0);

    a_r2_follow_next: assert property (@(posedge clk) disable iff (rst)
        step_en |=> pc == $past(next_pc));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc));

    a_r3_plain_sequential: assert property (@(posedge clk) disable iff (rst)
        !is_ctl |-> (next_pc == pc + 32'd4) && !link_we);

    a_r4_beq_unequal_falls_through: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BR_EQ && rs_value != rt_value) |-> next_pc == pc + 32'd4);

    a_r5_bne_equal_falls_through: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BR_NE && rs_value == rt_value) |-> next_pc == pc + 32'd4);

    a_r6_jump_keeps_region: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JABS) |-> (next_pc[31:28] == pc[31:28]) && (next_pc[1:0] == 2'b00));

    a_r7_link_fields: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == pc + 32'd4) && (link_dst == 5'd31));

    a_r8_jreg_target: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_SPECIAL && instr_word[FN_W-1:0] == FN_JREG) |-> next_pc == rs_value);

    a_r9_link_only_call: assert property (@(posedge clk) disable iff (rst)
        link_we |-> op == OPC_JCALL);
endmodule

bind npc_unit npc_unit_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .instr_word (instr_word),
    .rs_value   (rs_value),
    .rt_value   (rt_value),
    .pc         (pc),
    .next_pc    (next_pc),
    .link_we    (link_we),
    .link_dst   (link_dst),
    .link_val   (link_val)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rs_value = '0;
    logic [31:0] rt_value = '0;
    logic [31:0] pc, next_pc, link_val;
    logic        link_we;
    logic [4:0]  link_dst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    npc_unit i_npc_unit (
        .clk(clk), .rst(rst), .step_en(step_en), .instr_word(instr_word),
        .rs_value(rs_value), .rt_value(rt_value), .pc(pc), .next_pc(next_pc),
        .link_we(link_we), .link_dst(link_dst), .link_val(link_val)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] enc_i(input int op, input logic [15:0] imm);
        return {6'(op), 5'd9, 5'd10, imm};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input logic [25:0] f);
        return {6'(op), f};
    endfunction
    function automatic logic [31:0] enc_r(input int fn);
        return {6'd0, 5'd31, 5'd0, 5'd0, 5'd0, 6'(fn)};
    endfunction

    // behavioural reference of the next address
    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] w,
                                             input logic [31:0] a, input logic [31:0] b);
        int op = int'(w[31:26]);
        logic signed [31:0] ofs = 32'(signed'(w[15:0]));
        logic [31:0] seq = p + 4;
        if (op == 4) return (a == b) ? seq + 32'(ofs * 4) : seq;
        if (op == 5) return (a != b) ? seq + 32'(ofs * 4) : seq;
        if (op == 2 || op == 3) return (p & 32'hF000_0000) | (32'(w[25:0]) * 4);
        if (op == 0 && w[5:0] == 6'd8) return a;
        return seq;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // apply one instruction at the negative edge and check the outputs
    task automatic apply(input string req, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_next, input logic exp_lwe);
        @(negedge clk);
        instr_word = w; rs_value = a; rt_value = b; step_en = 1'b0;
        #2;
        chk(req, "next_pc", next_pc, exp_next);
        chk(req, "next_pc vs model", next_pc, ref_next(pc, w, a, b));
        chk(req, "link_we", 32'(link_we), 32'(exp_lwe));
    endtask

    // move the counter with a register jump and check it arrived (R2, R8)
    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        instr_word = enc_r(8); rs_value = v; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        #2;
        chk("R2", "pc after step", pc, v);
    endtask

    task automatic t_reset;
        @(negedge clk);
        #2;
        chk("R1", "pc in reset", pc, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "pc after reset", pc, 32'd0);
        chk("R3", "next_pc at 0", next_pc, 32'd4);
    endtask

    task automatic t_sequential;
        apply("R3", enc_i(8, 16'h0005), 0, 0, 32'd4, 0);
        apply("R3", enc_i(35, 16'hFFF0), 1, 1, 32'd4, 0);
        apply("R3", enc_r(32), 7, 9, 32'd4, 0);
        apply("R3", enc_i(6, 16'h0003), 5, 5, 32'd4, 0);
        @(negedge clk);
        instr_word = enc_i(43, 16'h0010); step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        #2;
        chk("R2", "pc stepped sequentially", pc, 32'd4);
    endtask

    task automatic t_hold;
        load_pc(32'h0000_0400);
        @(negedge clk);
        instr_word = enc_j(2, 26'h100);
        @(negedge clk);
        #2;
        chk("R2", "pc held with step_en low", pc, 32'h0000_0400);
    endtask

    task automatic t_beq;
        load_pc(32'd80012);
        apply("R4", enc_i(4, 16'd2), 32'd77, 32'd77, 32'd80024, 0);
        apply("R4", enc_i(4, 16'd2), 32'd77, 32'd78, 32'd80016, 0);
        load_pc(32'h0000_1000);
        apply("R4", enc_i(4, 16'hFFFD), 3, 3, 32'h0000_0FF8, 0);
        load_pc(32'h0004_0000);
        apply("R4", enc_i(4, 16'h8000), 9, 9, 32'h0002_0004, 0);
        apply("R4", enc_i(4, 16'h7FFF), 9, 9, 32'h0006_0000, 0);
    endtask

    task automatic t_bne;
        load_pc(32'h0000_2000);
        apply("R5", enc_i(5, 16'hFFFF), 1, 2, 32'h0000_2000, 0);
        apply("R5", enc_i(5, 16'hFFFF), 2, 2, 32'h0000_2004, 0);
        apply("R5", enc_i(5, 16'h0010), 32'hFFFF_FFFF, 0, 32'h0000_2044, 0);
    endtask

    task automatic t_jump;
        load_pc(32'd80024);
        apply("R6", enc_j(2, 26'd20000), 0, 0, 32'd80000, 0);
        load_pc(32'hA000_0010);
        apply("R6", enc_j(2, 26'h3FF_FFFF), 0, 0, 32'hAFFF_FFFC, 0);
        apply("R6", enc_j(2, 26'h0), 0, 0, 32'hA000_0000, 0);
    endtask

    task automatic t_jal;
        load_pc(32'h7000_0100);
        apply("R7", enc_j(3, 26'h40), 0, 0, 32'h7000_0100, 1);
        chk("R7", "link_val", link_val, 32'h7000_0104);
        chk("R7", "link_dst", 32'(link_dst), 32'd31);
        @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        #2;
        chk("R7", "pc after call", pc, 32'h7000_0100);
    endtask

    task automatic t_jreg;
        load_pc(32'h0000_0800);
        apply("R8", enc_r(8), 32'h1234_5678, 0, 32'h1234_5678, 0);
        apply("R8", enc_r(9), 32'h1234_5678, 0, 32'h0000_0804, 0);
        apply("R9", enc_i(4, 16'd1), 4, 4, 32'h0000_0808, 0);
        apply("R9", enc_j(2, 26'h10), 0, 0, 32'h0000_0040, 0);
    endtask

    task automatic t_reset_again;
        load_pc(32'h0000_0C00);
        @(negedge clk);
        rst = 1'b1; step_en = 1'b1;
        @(negedge clk);
        #2;
        chk("R1", "pc after mid-run reset", pc, 32'd0);
        rst = 1'b0; step_en = 1'b0;
    endtask

    initial begin
        t_reset;
        t_sequential;
        t_hold;
        t_beq;
        t_bne;
        t_jump;
        t_jal;
        t_jreg;
        t_reset_again;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end
endmodule